// File: doc/BRIEF.md
# Floating-Point Data Class Tester

This block takes one IEEE 754 binary floating-point operand in single, double or quad precision and reports whether its class and sign are selected by a 12-bit selection mask. The operand is decoded into exactly one of six classes: zero, normal, subnormal, infinity, quiet NaN or signaling NaN. The class and the sign bit together pick one mask bit, and the registered one-bit result is that bit's value. The block reads and classifies its input only. It performs no arithmetic, raises no exceptions and has no rounding state.

The operand arrives on two 64-bit halves that form a 128-bit word. A format select chooses the width, and the narrower formats sit in the low end of that word. A request is marked by an input valid strobe. The result and an output valid appear one clock later.

Top module: `fp_class_test`

## Requirements
- R1: Mask bit n is found at vector position 11−n of the 12 defined mask bits. The class base indices are zero=0, normal=2, subnormal=4, infinity=6, quiet NaN=8 and signaling NaN=10. The tested bit n is the base plus the sign bit, so a positive operand uses the even bit and a negative operand uses the odd bit.
- R2: The result is 1 exactly when the mask bit picked by the operand's class and sign is set. In particular, a mask whose 12 defined bits are all zero always gives 0.
- R3: An operand whose exponent field is all zeros and whose fraction is zero is classed as zero, for either sign.
- R4: An operand whose exponent field is all zeros and whose fraction is nonzero is classed as subnormal and never as normal. An operand whose exponent is neither all zeros nor all ones is classed as normal.
- R5: An operand whose exponent field is all ones and whose fraction is zero is classed as infinity.
- R6: An operand whose exponent field is all ones and whose fraction is nonzero is a NaN. It is quiet when the top fraction bit is 1. It is signaling when the top fraction bit is 0 and the rest of the fraction is nonzero. Each NaN kind is tested only against its own mask pair.
- R7: The format select `fmt_sel` uses 2'b00 for 32-bit (8-bit exponent, 23-bit fraction, operand in bits [31:0]), 2'b01 for 64-bit (11-bit exponent, 52-bit fraction, bits [63:0]) and 2'b10 for 128-bit (15-bit exponent, 112-bit fraction, the whole word). Bits above the chosen width are ignored. The 128-bit word is {`opnd_hi`, `opnd_lo`}.
- R8: A format select of 2'b11 forces the result to 0 whatever the operand and mask.
- R9: Mask input bits [15:12] have no effect on the result. Only bits [11:0] are defined.
- R10: `out_valid` is 1 in the cycle after `in_valid` is sampled high and 0 otherwise. `out_hit` loads only when `in_valid` is sampled high and holds its value otherwise.
- R11: Reset clears `out_valid` and `out_hit` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe; operand, format and mask are sampled when it is high |
| fmt_sel | input | 2 | Operand format: 00 single, 01 double, 10 quad, 11 invalid |
| opnd_hi | input | 64 | Upper half of the 128-bit operand word |
| opnd_lo | input | 64 | Lower half of the 128-bit operand word |
| mask_in | input | 16 | Class-and-sign selection mask; bits [11:0] defined |
| out_valid | output | 1 | Result valid, one cycle after a sampled request |
| out_hit | output | 1 | 1 when the selected mask bit for the operand's class and sign is set |

## Verification
The bench sweeps a one-hot mask and its complement across every class, sign and format. A design that reversed the bit numbering or swapped the sign within a pair would answer for the wrong class or the wrong sign. Operands on the edges between classes are driven for each format: the smallest and largest subnormal, the smallest normal, infinity, and NaNs whose only set fraction bit is either the top bit or the lowest bit. A design that folded subnormals into normals, or judged NaN quietness by the wrong bit, would miss these. Random garbage is placed above the operand width, and only bits [15:12] of the mask are set in some requests, to catch designs that read beyond the defined fields. Idle cycles check that the result holds and that the invalid format code yields 0.

// File: rtl/fpdc_pkg.sv
package fpdc_pkg;

  localparam int NUM_FMT  = 3;
  localparam int MASK_W   = 12;
  localparam int CLS_W    = 3;
  localparam int WORD_W   = 128;

  typedef enum logic [CLS_W-1:0] {
    CLS_ZERO = 3'd0,
    CLS_NORM = 3'd1,
    CLS_SUB  = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_class_e;

  function automatic int fmt_exp_w(input int f);
    case (f)
      0:       return 8;
      1:       return 11;
      default: return 15;
    endcase
  endfunction

  function automatic int fmt_frac_w(input int f);
    case (f)
      0:       return 23;
      1:       return 52;
      default: return 112;
    endcase
  endfunction

endpackage

// File: rtl/fpdc_classify.sv
module fpdc_classify
  import fpdc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output fp_class_e             cls,
  output logic                  neg
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero;
  logic              exp_ones;
  logic              frac_zero;

  assign neg       = word[EXP_W+FRAC_W];
  assign exp_f     = word[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f    = word[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  always_comb begin
    if (exp_zero) begin
      cls = frac_zero ? CLS_ZERO : CLS_SUB;
    end else if (exp_ones) begin
      if (frac_zero)                cls = CLS_INF;
      else if (frac_f[FRAC_W-1])    cls = CLS_QNAN;
      else                          cls = CLS_SNAN;
    end else begin
      cls = CLS_NORM;
    end
  end

endmodule

// File: rtl/fpdc_select.sv
module fpdc_select
  import fpdc_pkg::*;
#(
  parameter int N_FMT = NUM_FMT,
  parameter int MW    = MASK_W
) (
  input  logic [N_FMT-1:0][CLS_W-1:0] cls_vec,
  input  logic [N_FMT-1:0]            neg_vec,
  input  logic [1:0]                  fmt,
  input  logic [MW-1:0]               mask,
  output logic                        hit
);

  localparam int IDX_W = $clog2(MW);

  logic [IDX_W-1:0] bit_num;
  logic [IDX_W-1:0] bit_pos;
  logic             fmt_ok;
  logic [CLS_W-1:0] cls_sel;
  logic             neg_sel;

  assign fmt_ok = (int'(fmt) < N_FMT);

  always_comb begin
    cls_sel = '0;
    neg_sel = 1'b0;
    for (int i = 0; i < N_FMT; i++) begin
      if (int'(fmt) == i) begin
        cls_sel = cls_vec[i];
        neg_sel = neg_vec[i];
      end
    end
  end

  // Bit number counts from the top of the mask: base = 2*class, plus sign.
  assign bit_num = IDX_W'({cls_sel, 1'b0}) + IDX_W'(neg_sel);
  assign bit_pos = IDX_W'(MW - 1) - bit_num;

  always_comb begin
    hit = 1'b0;
    if (fmt_ok && (int'(bit_num) < MW)) hit = mask[bit_pos];
  end

endmodule

// File: rtl/fp_class_test.sv
module fp_class_test
  import fpdc_pkg::*;
#(
  parameter int HALF_W    = 64,
  parameter int MASK_IN_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           fmt_sel,
  input  logic [HALF_W-1:0]    opnd_hi,
  input  logic [HALF_W-1:0]    opnd_lo,
  input  logic [MASK_IN_W-1:0] mask_in,
  output logic                 out_valid,
  output logic                 out_hit
);

  localparam int FULL_W = 2 * HALF_W;

  logic [1:0]                    rst_sync_q;
  logic                          rst_int_n;
  logic [FULL_W-1:0]             word;
  logic [NUM_FMT-1:0][CLS_W-1:0] cls_vec;
  logic [NUM_FMT-1:0]            neg_vec;
  logic                          sel_hit;
  logic                          valid_d, valid_q;
  logic                          hit_d, hit_q;

  // Reset: asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign word = {opnd_hi, opnd_lo};

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = fmt_exp_w(g);
    localparam int FW = fmt_frac_w(g);
    fp_class_e cls_g;
    fpdc_classify #(.EXP_W(EW), .FRAC_W(FW)) u_cls (
      .word (word[EW+FW:0]),
      .cls  (cls_g),
      .neg  (neg_vec[g])
    );
    assign cls_vec[g] = cls_g;
  end

  fpdc_select #(.N_FMT(NUM_FMT), .MW(MASK_W)) u_sel (
    .cls_vec (cls_vec),
    .neg_vec (neg_vec),
    .fmt     (fmt_sel),
    .mask    (mask_in[MASK_W-1:0]),
    .hit     (sel_hit)
  );

  always_comb begin
    valid_d = in_valid;
    hit_d   = hit_q;
    if (in_valid) hit_d = sel_hit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= hit_d;
    end
  end

  assign out_valid = valid_q;
  assign out_hit   = hit_q;

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  assert_valid_source_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> $past(in_valid));
  assert_hit_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(out_hit));
  assert_bad_fmt_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && fmt_sel == 2'b11) |=> !out_hit);
  assert_empty_mask_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && mask_in[MASK_W-1:0] == '0) |=> !out_hit);

endmodule

// File: tb/tb_fp_class_test.sv
`timescale 1ns/1ps
module tb_fp_class_test;

  localparam int CLK_P = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  fmt_sel;
  logic [63:0] opnd_hi, opnd_lo;
  logic [15:0] mask_in;
  logic        out_valid, out_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  fp_class_test dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
    .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .mask_in(mask_in),
    .out_valid(out_valid), .out_hit(out_hit)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int ew_of(input int f);
    return (f == 0) ? 8 : (f == 1) ? 11 : 15;
  endfunction
  function automatic int fw_of(input int f);
    return (f == 0) ? 23 : (f == 1) ? 52 : 112;
  endfunction

  // Class index 0..5: zero, normal, subnormal, infinity, qnan, snan.
  function automatic int ref_class(input int f, input logic [127:0] op);
    int ew = ew_of(f);
    int fw = fw_of(f);
    logic [127:0] emask = (128'd1 << ew) - 128'd1;
    logic [127:0] fmask = (128'd1 << fw) - 128'd1;
    logic [127:0] e = (op >> fw) & emask;
    logic [127:0] fr = op & fmask;
    if (e == 0) return (fr == 0) ? 0 : 2;
    if (e == emask) begin
      if (fr == 0) return 3;
      return fr[fw-1] ? 4 : 5;
    end
    return 1;
  endfunction

  function automatic bit ref_hit(input logic [1:0] f, input logic [127:0] op,
                                 input logic [15:0] m);
    int n;
    if (f == 2'b11) return 1'b0;
    n = 2 * ref_class(int'(f), op) + int'(op[ew_of(int'(f)) + fw_of(int'(f))]);
    return m[11 - n];
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Build an operand of a given class and sign with random garbage above it.
  function automatic logic [127:0] make_op(input int f, input int cls, input bit s);
    int ew = ew_of(f);
    int fw = fw_of(f);
    logic [127:0] emask = (128'd1 << ew) - 128'd1;
    logic [127:0] fmask = (128'd1 << fw) - 128'd1;
    logic [127:0] fieldm = (128'd1 << (ew + fw + 1)) - 128'd1;
    logic [127:0] op = rnd128();
    logic [127:0] fr = rnd128() & fmask;
    logic [127:0] e;
    case (cls)
      0: begin e = 0; fr = 0; end
      1: e = 128'(($urandom % (int'(emask) - 1)) + 1);
      2: begin e = 0; if (fr == 0) fr = 1; end
      3: begin e = emask; fr = 0; end
      4: begin e = emask; fr[fw-1] = 1'b1; end
      default: begin
        e = emask; fr[fw-1] = 1'b0; if (fr == 0) fr = 1;
      end
    endcase
    op = (op & ~fieldm) | (128'(s) << (ew + fw)) | (e << fw) | fr;
    if (f == 2) op = (128'(s) << 127) | (e << fw) | fr;
    return op;
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge, check the result one cycle later.
  task automatic run(input logic [1:0] f, input logic [127:0] op,
                     input logic [15:0] m, input string req);
    bit e;
    @(negedge clk);
    in_valid = 1'b1; fmt_sel = f; {opnd_hi, opnd_lo} = op; mask_in = m;
    e = ref_hit(f, op, m);
    @(negedge clk);
    check(out_valid, 1'b1, "R10");
    check(out_hit, e, req);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; in_valid = 1'b0; fmt_sel = 2'b00;
    opnd_hi = '0; opnd_lo = '0; mask_in = '0;
    repeat (3) @(negedge clk);
    check(out_valid, 1'b0, "R11");
    check(out_hit, 1'b0, "R11");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid, 1'b0, "R11");

    // R1: one-hot and complement masks across every class, sign and format.
    for (int f = 0; f < 3; f++)
      for (int c = 0; c < 6; c++)
        for (int s = 0; s < 2; s++) begin
          logic [127:0] op = make_op(f, c, s[0]);
          logic [15:0] oh = 16'd1 << (11 - (2 * c + s));
          run(2'(f), op, oh, "R1");
          run(2'(f), op, ~oh & 16'h0FFF, "R1");
          run(2'(f), op, oh ^ 16'h0001 ^ 16'h0800, "R2");
        end

    // R3..R6: class boundaries per format.
    for (int f = 0; f < 3; f++) begin
      int ew = ew_of(f);
      int fw = fw_of(f);
      logic [127:0] top = 128'd1 << (fw - 1);
      logic [127:0] fm = (128'd1 << fw) - 128'd1;
      logic [127:0] em = ((128'd1 << ew) - 128'd1) << fw;
      run(2'(f), 128'd0, 16'h0800, "R3");
      run(2'(f), 128'd1 << (ew + fw), 16'h0400, "R3");
      run(2'(f), 128'd1, 16'h0080, "R4");
      run(2'(f), fm, 16'h0080, "R4");
      run(2'(f), fm, 16'h0200, "R4");
      run(2'(f), 128'd1 << fw, 16'h0200, "R4");
      run(2'(f), em - (128'd1 << fw) | fm, 16'h0200, "R4");
      run(2'(f), em, 16'h0020, "R5");
      run(2'(f), em | top, 16'h0008, "R6");
      run(2'(f), em | top, 16'h0002, "R6");
      run(2'(f), em | 128'd1, 16'h0002, "R6");
      run(2'(f), em | 128'd1, 16'h0008, "R6");
      run(2'(f), em | fm, 16'h0008, "R6");
    end

    // R7: garbage above a narrow operand must not matter.
    run(2'b00, {64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}, 16'h0800, "R7");
    run(2'b01, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001}, 16'h0080, "R7");
    run(2'b10, {64'h7FFF_0000_0000_0000, 64'h0}, 16'h0020, "R7");

    // R8 and R9.
    for (int c = 0; c < 6; c++) begin
      run(2'b11, make_op(2, c, 1'b0), 16'hFFFF, "R8");
      run(2'b11, make_op(0, c, 1'b1), 16'hFFFF, "R8");
      run(2'($urandom % 3), make_op(1, c, c[0]), 16'hF000, "R9");
    end

    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      int f = $urandom % 4;
      int fc = (f == 3) ? 2 : f;
      run(2'(f), make_op(fc, $urandom % 6, 1'($urandom)), 16'($urandom), "R2");
    end

    // R10: idle cycles hold the result and clear valid.
    run(2'b00, 128'd0, 16'h0800, "R3");
    @(negedge clk);
    in_valid = 1'b0; mask_in = 16'h0000; opnd_lo = 64'h7F80_0000;
    @(negedge clk);
    check(out_valid, 1'b0, "R10");
    check(out_hit, 1'b1, "R10");
    @(negedge clk);
    check(out_hit, 1'b1, "R10");

    // R11: reset mid-run clears the outputs.
    run(2'b00, 128'd0, 16'h0800, "R3");
    rst_n = 1'b0;
    #1;
    check(out_valid, 1'b0, "R11");
    check(out_hit, 1'b0, "R11");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule